// File: doc/BRIEF.md
# Memory-Reference Instruction Sequencer

This block carries out the six memory-touching instructions of a small accumulator machine with a 16-bit word. Fetch and address formation happen outside the block. It receives a decoded 3-bit opcode and a final effective address together with a one-cycle `start` strobe. It then steps through a short state sequence against a synchronous single-port memory. The memory returns read data one cycle after the address is sampled.

The block holds the architectural registers it changes. These are the accumulator, the link bit, the memory buffer and the program counter. When the block accepts `start`, the program counter already points at the next sequential instruction. The block raises `done` for one cycle when the instruction has retired. The surrounding control waits for `done` and then issues the next instruction.

Top module: `mri_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `acc`, `link`, `mbuf` and `pc`, returns to idle, and holds `done` low.
- R2: Opcode 0 (logical product) reads the word at the effective address and replaces `acc` with `acc & word`. `link` and `pc` do not change.
- R3: Opcode 1 (add) reads the word and writes the low 16 bits of `acc + word` to `acc`. A carry out of bit 15 complements `link`; with no carry, `link` keeps its value.
- R4: Opcode 2 (increment and skip) reads the word, places `word + 1` (modulo 2^16) in `mbuf`, and writes that value back to the same address. If the value is zero, `pc` advances by one; otherwise `pc` does not change.
- R5: Opcode 3 (deposit) writes `acc` to the effective address and then sets `acc` to zero.
- R6: Opcode 4 (call) writes the current `pc`, zero-extended to 16 bits, to the effective address and sets `pc` to the effective address plus one, modulo 2^12.
- R7: Opcode 5 (jump) sets `pc` to the effective address. There is no memory write.
- R8: Opcodes 6 and 7 retire on the first edge after `start`, leave `acc`, `link`, `mbuf`, `pc` and memory unchanged, and make no memory write.
- R9: `done` is high for exactly one cycle per accepted instruction. Count edges from the one that samples `start`, which is edge 1. `done` rises on edge 3 for opcodes 0 and 1, on edge 4 for opcode 2, on edge 2 for opcodes 3, 4 and 5, and on edge 1 for opcodes 6 and 7. The block ignores `start` while an instruction is in progress.
- R10: The block drives `mem_addr` with the effective address and raises `mem_we` only in a write cycle. The edge that ends a write cycle also retires the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the presented instruction (accepted only when idle) |
| opcode | input | 3 | Decoded instruction: 0 product, 1 add, 2 increment-skip, 3 deposit, 4 call, 5 jump |
| eaddr | input | 12 | Effective address |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| mbuf | output | 16 | Memory buffer |
| pc | output | 12 | Program counter |
| done | output | 1 | One-cycle retire pulse |

## Verification
The bench targets the carry into the link bit on add, including an add with no carry after the link has been set. A design that cleared or forced the link would show a wrong `link` there. The bench steps increment-and-skip from 0xFFFE to 0xFFFF and then to zero, so a skip taken on the wrong value, or a missing write-back, shows up as a wrong `pc` or a wrong memory word. It runs a call at address 0xFFF, where a return address that fails to wrap would be visible. It also holds `start` for a second cycle and issues undefined opcodes. A design that restarted, or that let an undefined code modify state, would produce an extra `done` or changed registers. Every retire is also timed, so a design that consumed the read data one cycle too early would load stale data and retire early.

// File: rtl/mri_seq.sv
module mri_seq #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    opcode,
  input  logic [AW-1:0] eaddr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc,
  output logic          link,
  output logic [DW-1:0] mbuf,
  output logic [AW-1:0] pc,
  output logic          done
);

  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_TAD = 3'd1;
  localparam logic [2:0] OP_ISZ = 3'd2;
  localparam logic [2:0] OP_DCA = 3'd3;
  localparam logic [2:0] OP_JMS = 3'd4;
  localparam logic [2:0] OP_JMP = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EXEC, S_WRITE} st_t;

  st_t           st;
  logic [2:0]    op_q;
  logic [AW-1:0] ea_q;
  logic [DW:0]   sum;
  logic [DW-1:0] inc_w;

  assign sum      = {1'b0, acc} + {1'b0, mem_rdata};
  assign inc_w    = mem_rdata + DW'(1);
  assign mem_addr = ea_q;
  assign mem_we   = (st == S_WRITE);
  assign mem_wdata = (op_q == OP_ISZ) ? mbuf :
                     (op_q == OP_DCA) ? acc  : DW'(pc);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      op_q <= '0;
      ea_q <= '0;
      acc  <= '0;
      link <= 1'b0;
      mbuf <= '0;
      pc   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= opcode;
          ea_q <= eaddr;
          case (opcode)
            OP_AND, OP_TAD, OP_ISZ: st <= S_READ;
            OP_DCA, OP_JMS:         st <= S_WRITE;
            OP_JMP:                 st <= S_EXEC;
            default:                done <= 1'b1;
          endcase
        end
        S_READ: st <= S_EXEC;
        S_EXEC: begin
          case (op_q)
            OP_AND: begin acc <= acc & mem_rdata; done <= 1'b1; st <= S_IDLE; end
            OP_TAD: begin
              acc  <= sum[DW-1:0];
              link <= link ^ sum[DW];
              done <= 1'b1;
              st   <= S_IDLE;
            end
            OP_ISZ: begin mbuf <= inc_w; st <= S_WRITE; end
            default: begin pc <= ea_q; done <= 1'b1; st <= S_IDLE; end
          endcase
        end
        S_WRITE: begin
          case (op_q)
            OP_ISZ:  if (mbuf == '0) pc <= pc + AW'(1);
            OP_DCA:  acc <= '0;
            default: pc <= ea_q + AW'(1);
          endcase
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_and_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && op_q == OP_AND) |=> acc == ($past(acc) & $past(mem_rdata)));

  p_tad_link_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && op_q == OP_TAD) |=>
      ({link ^ $past(link), acc} == ({1'b0, $past(acc)} + {1'b0, $past(mem_rdata)})));

  p_isz_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && op_q == OP_ISZ && mbuf == '0) |=> pc == $past(pc) + AW'(1));

  p_dca_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && op_q == OP_DCA) |=> acc == '0);

  p_jms_target_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && op_q == OP_JMS) |=> pc == $past(ea_q) + AW'(1));

  p_jmp_target_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && op_q == OP_JMP) |=> pc == $past(ea_q));

  p_bad_op_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start && opcode > OP_JMP) |=>
      (done && !mem_we && $stable(acc) && $stable(pc) && $stable(link) && $stable(mbuf)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_write_retires_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (done && !mem_we));

endmodule

// File: tb/mri_seq_test.sv
`timescale 1ns/1ps
module mri_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  opcode = '0;
  logic [11:0] eaddr = '0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, acc, mbuf;
  logic        mem_we, link, done;
  logic [11:0] pc;

  logic        pre_we = 1'b0;
  logic [11:0] pre_a = '0;
  logic [15:0] pre_d = '0;
  logic [15:0] mem [0:4095];

  int checks = 0, errors = 0, cyc = 0;

  typedef struct {
    logic [15:0] acc; logic link; logic [11:0] pc;
    logic mchk; logic [11:0] ma; logic [15:0] mv;
    logic mbchk; logic [15:0] mb;
    int lat; int t0; string req;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_acc = '0, m_mb = '0;
  logic        m_link = 1'b0;
  logic [11:0] m_pc = '0;

  mri_seq uut (.clk(clk), .rst(rst), .start(start), .opcode(opcode), .eaddr(eaddr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .acc(acc), .link(link), .mbuf(mbuf), .pc(pc), .done(done));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (pre_we) mem[pre_a] <= pre_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); pre_we = 1'b1; pre_a = a; pre_d = d;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic run(input logic [2:0] op, input logic [11:0] ea, input string req,
                     input int hold = 1);
    exp_t e;
    logic [16:0] s;
    logic [15:0] v;
    @(negedge clk);
    start = 1'b1; opcode = op; eaddr = ea;
    e.t0 = cyc; e.req = req; e.mchk = 1'b0; e.mbchk = 1'b0; e.ma = ea; e.mv = '0; e.mb = '0;
    case (op)
      3'd0: begin m_acc = m_acc & mem[ea]; e.lat = 3; end
      3'd1: begin s = {1'b0, m_acc} + {1'b0, mem[ea]}; m_acc = s[15:0];
                  m_link = m_link ^ s[16]; e.lat = 3; end
      3'd2: begin v = mem[ea] + 16'd1; m_mb = v; e.mbchk = 1'b1; e.mchk = 1'b1; e.mv = v;
                  if (v == 16'd0) m_pc = m_pc + 12'd1; e.lat = 4; end
      3'd3: begin e.mchk = 1'b1; e.mv = m_acc; m_acc = '0; e.lat = 2; end
      3'd4: begin e.mchk = 1'b1; e.mv = {4'd0, m_pc}; m_pc = ea + 12'd1; e.lat = 2; end
      3'd5: begin m_pc = ea; e.lat = 2; end
      default: begin e.mchk = 1'b1; e.mv = mem[ea]; e.mbchk = 1'b1; e.lat = 1; end
    endcase
    e.acc = m_acc; e.link = m_link; e.pc = m_pc; e.mb = m_mb;
    q.push_back(e);
    repeat (hold) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc - e.t0 == e.lat, "R9", {e.req, " latency"}, cyc - e.t0, e.lat);
        chk(acc == e.acc, e.req, "acc", acc, e.acc);
        chk(link == e.link, e.req, "link", link, e.link);
        chk(pc == e.pc, e.req, "pc", pc, e.pc);
        if (e.mchk) chk(mem[e.ma] == e.mv, e.req, "memory word", mem[e.ma], e.mv);
        if (e.mbchk) chk(mbuf == e.mb, e.req, "mbuf", mbuf, e.mb);
      end
    end
  end

  initial begin
    repeat (25000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    poke(12'h010, 16'h0F0F);
    poke(12'h011, 16'hFFFF);
    poke(12'h012, 16'h8001);
    poke(12'h013, 16'hFFFE);
    poke(12'h014, 16'h0000);
    poke(12'h030, 16'h1234);
    poke(12'h200, 16'h5555);
    poke(12'hFFF, 16'hAAAA);
    @(negedge clk);
    chk(acc == 0 && link == 0 && pc == 0 && mbuf == 0, "R1", "regs after reset",
        {acc, 3'b0, link, pc}, 32'd0);
    chk(done == 0, "R1", "done in reset", done, 0);
    rst = 1'b0;

    run(3'd1, 12'h010, "R3");            // load 0F0F, no carry
    run(3'd0, 12'h011, "R2");            // AND with FFFF
    run(3'd1, 12'h011, "R3");            // carry: link -> 1
    run(3'd1, 12'h012, "R3");            // no carry: link stays 1
    run(3'd0, 12'h012, "R2");            // AND 8F0F & 8001
    run(3'd5, 12'h100, "R7");
    run(3'd4, 12'h200, "R6");            // mem[200]=100, pc=201
    run(3'd2, 12'h013, "R4");            // FFFE -> FFFF, no skip
    run(3'd2, 12'h013, "R4");            // FFFF -> 0000, skip
    run(3'd1, 12'h010, "R10");           // read after write-back address
    run(3'd3, 12'h030, "R5");
    run(3'd6, 12'h030, "R8");
    run(3'd7, 12'h010, "R8");
    run(3'd0, 12'h011, "R9", 2);         // start held while busy
    run(3'd1, 12'h011, "R3");            // FFFF+0 with acc 0 then
    run(3'd4, 12'hFFF, "R6");            // wrap to 000
    run(3'd2, 12'h014, "R4");            // 0 -> 1
    run(3'd3, 12'h031, "R5");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9", "pending retires", q.size(), 0);
    chk(!done && !mem_we, "R10", "quiet when idle", {done, mem_we}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule